// File: doc/BRIEF.md
# Edge and Level Interrupt Controller

This block gathers interrupt requests from up to 32 sources and turns them into two CPU request lines and one wake-from-idle line. Every source picks its input from either a peripheral wire, which is brought into the clock domain through a two-flop synchronizer, or a bit in a software test word. A three-bit trigger mode per source decides whether the source reacts to rising edges, falling edges, high or low levels, or a mix of these. Captured edges are held in two status words until software clears them.

Software sees the block through a simple byte-addressed register bus. Each control word is reached at two offsets. A write of ones at the lower offset sets bits, and the same offset returns the word on a read. A write of ones at the offset four bytes higher clears bits. The control words are the three mode bit-planes, the source select, the line routing, the wake enable and the mask. Two of the clear offsets (0x54 and 0x5C) return the per-line pending status when read.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every control word, the test word and both capture words read 0, and `req0_o`, `req1_o` and `wake_o` are low.
- R2: A write at a set offset (0x40 mode bit0, 0x48 mode bit1, 0x50 mode bit2, 0x58 select, 0x60 route, 0x68 wake, 0x70 mask) sets only the bits written as 1. A write at that offset plus 4 clears only the bits written as 1. Reads at the set offset return the word.
- R3: Select bit 1 takes the peripheral input through a two-stage synchronizer, so the source is seen two clock edges after the wire changes. Select bit 0 takes bit n of the test word at 0x80, and the peripheral wire is then ignored.
- R4: A mode {bit2,bit1,bit0} of 001 captures rising edges only, 010 falling edges only, and 011 both. Captures show in the rising word at 0x78 and the falling word at 0x7C.
- R5: Mode 101 is active while the input is high, and mode 110 while it is low. Modes 000 and 100 are never active and capture nothing.
- R6: Mode 111 is active at all times and also captures both edges.
- R7: Writing 1 to a capture bit at 0x78 or 0x7C clears it, unless a new enabled edge arrives in the same cycle. In that case the bit stays set. A capture bit never clears without such a write.
- R8: A source with mask bit 0 drives neither request line. With the mask word all 0, both request lines are low one cycle later.
- R9: A source is active when it has a captured edge or its level condition holds. Route bit 1 sends an active unmasked source to `req0_o`, and route bit 0 sends it to `req1_o`. Each output is registered and equals the OR over its sources, one cycle after the status. Reads at 0x54 and 0x5C return the routed active unmasked sources for line 0 and line 1.
- R10: `wake_o` is the registered OR over active sources with their wake bit set. It ignores the mask.
- R11: A write at 0x54 clears bits of mode bit2, and a write at 0x5C clears bits of the select word, even though reads at those offsets return status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | N_SRC | Write data |
| bus_rdata_o | output | N_SRC | Read data for `bus_addr_i`, combinational |
| periph_irq_i | input | N_SRC | Asynchronous peripheral interrupt wires |
| req0_o | output | 1 | CPU request line 0 |
| req1_o | output | 1 | CPU request line 1 |
| wake_o | output | 1 | Wake-from-idle request |

## Verification
The bench builds the block with its defaults: 32 sources, an 8-bit offset and two synchronizer stages. This puts every offset from 0x40 to 0x80 and the full bit span of each word in reach. The source tests use distinct bits, so a crossed bit-plane or a wrong route shows up as the wrong status bit. Using two stages gives an exact one-edge and two-edge observation point for the peripheral path. A test bit toggled one edge before a capture clear sets up the same-cycle collision of a new edge and a clear.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int NUM_CW = 7;
  localparam int CW_CFG0 = 0;
  localparam int CW_CFG1 = 1;
  localparam int CW_CFG2 = 2;
  localparam int CW_SRC  = 3;
  localparam int CW_ASG  = 4;
  localparam int CW_WAKE = 5;
  localparam int CW_MASK = 6;

  localparam logic [7:0] OFF_REQ0 = 8'h54;
  localparam logic [7:0] OFF_REQ1 = 8'h5C;
  localparam logic [7:0] OFF_RISE = 8'h78;
  localparam logic [7:0] OFF_FALL = 8'h7C;
  localparam logic [7:0] OFF_TEST = 8'h80;
  localparam logic [7:0] OFF_MASK = 8'h70;

  typedef enum logic [2:0] {
    TM_OFF   = 3'b000,
    TM_RISE  = 3'b001,
    TM_FALL  = 3'b010,
    TM_EDGES = 3'b011,
    TM_OFF2  = 3'b100,
    TM_HIGH  = 3'b101,
    TM_LOW   = 3'b110,
    TM_ALL   = 3'b111
  } trig_mode_e;

  // set offset of control word k; clear port is +4
  function automatic logic [7:0] cw_set_off(int k);
    case (k)
      CW_CFG0: return 8'h40;
      CW_CFG1: return 8'h48;
      CW_CFG2: return 8'h50;
      CW_SRC:  return 8'h58;
      CW_ASG:  return 8'h60;
      CW_WAKE: return 8'h68;
      default: return 8'h70;
    endcase
  endfunction

  function automatic logic rise_en(trig_mode_e m);
    return (m == TM_RISE) || (m == TM_EDGES) || (m == TM_ALL);
  endfunction

  function automatic logic fall_en(trig_mode_e m);
    return (m == TM_FALL) || (m == TM_EDGES) || (m == TM_ALL);
  endfunction

  function automatic logic high_en(trig_mode_e m);
    return (m == TM_HIGH) || (m == TM_ALL);
  endfunction

  function automatic logic low_en(trig_mode_e m);
    return (m == TM_LOW) || (m == TM_ALL);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] mode_i,
  input  logic       raw_i,
  input  logic       rise_clr_i,
  input  logic       fall_clr_i,
  output logic       rise_o,
  output logic       fall_o,
  output logic       active_o
);
  trig_mode_e mode;
  logic prev_q, rise_q, fall_q;
  logic rise_evt, fall_evt;

  assign mode     = trig_mode_e'(mode_i);
  assign rise_evt = raw_i & ~prev_q & rise_en(mode);
  assign fall_evt = ~raw_i & prev_q & fall_en(mode);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= raw_i;
      // a fresh edge outranks a clear in the same cycle
      rise_q <= (rise_q & ~rise_clr_i) | rise_evt;
      fall_q <= (fall_q & ~fall_clr_i) | fall_evt;
    end
  end

  assign rise_o   = rise_q;
  assign fall_o   = fall_q;
  assign active_o = rise_q | fall_q
                  | (high_en(mode) & raw_i)
                  | (low_en(mode) & ~raw_i);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC       = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [N_SRC-1:0]  bus_wdata_i,
  output logic [N_SRC-1:0]  bus_rdata_o,
  input  logic [N_SRC-1:0]  periph_irq_i,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic [N_SRC-1:0] ctl_q [NUM_CW];
  logic [N_SRC-1:0] test_q;
  logic [N_SRC-1:0] periph_s, raw, rise, fall, active;
  logic [N_SRC-1:0] rise_clr, fall_clr;
  logic [N_SRC-1:0] pend0, pend1;
  logic [N_SRC-1:0] mask_w, asg_w, wake_w;

  for (genvar k = 0; k < NUM_CW; k++) begin : g_cw
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(cw_set_off(k));
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(cw_set_off(k) + 8'd4);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_q[k] <= '0;
      else if (bus_wr_i && bus_addr_i == SET_A) ctl_q[k] <= ctl_q[k] | bus_wdata_i;
      else if (bus_wr_i && bus_addr_i == CLR_A) ctl_q[k] <= ctl_q[k] & ~bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) test_q <= '0;
    else if (bus_wr_i && bus_addr_i == ADDR_W'(OFF_TEST)) test_q <= bus_wdata_i;
  end

  irq_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (periph_irq_i),
    .q_o   (periph_s)
  );

  assign rise_clr = (bus_wr_i && bus_addr_i == ADDR_W'(OFF_RISE)) ? bus_wdata_i : '0;
  assign fall_clr = (bus_wr_i && bus_addr_i == ADDR_W'(OFF_FALL)) ? bus_wdata_i : '0;

  for (genvar n = 0; n < N_SRC; n++) begin : g_src
    assign raw[n] = ctl_q[CW_SRC][n] ? periph_s[n] : test_q[n];
    irq_src_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    ({ctl_q[CW_CFG2][n], ctl_q[CW_CFG1][n], ctl_q[CW_CFG0][n]}),
      .raw_i     (raw[n]),
      .rise_clr_i(rise_clr[n]),
      .fall_clr_i(fall_clr[n]),
      .rise_o    (rise[n]),
      .fall_o    (fall[n]),
      .active_o  (active[n])
    );
  end

  assign mask_w = ctl_q[CW_MASK];
  assign asg_w  = ctl_q[CW_ASG];
  assign wake_w = ctl_q[CW_WAKE];
  assign pend0  = active & mask_w & asg_w;
  assign pend1  = active & mask_w & ~asg_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req0_o <= 1'b0;
      req1_o <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      req0_o <= |pend0;
      req1_o <= |pend1;
      wake_o <= |(active & wake_w);
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int k = 0; k < NUM_CW; k++)
      if (bus_addr_i == ADDR_W'(cw_set_off(k))) bus_rdata_o = ctl_q[k];
    if (bus_addr_i == ADDR_W'(OFF_REQ0)) bus_rdata_o = pend0;
    if (bus_addr_i == ADDR_W'(OFF_REQ1)) bus_rdata_o = pend1;
    if (bus_addr_i == ADDR_W'(OFF_RISE)) bus_rdata_o = rise;
    if (bus_addr_i == ADDR_W'(OFF_FALL)) bus_rdata_o = fall;
    if (bus_addr_i == ADDR_W'(OFF_TEST)) bus_rdata_o = test_q;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [N_SRC-1:0]  bus_wdata_i,
  input logic              req0_o,
  input logic              req1_o,
  input logic              wake_o,
  input logic [N_SRC-1:0]  active,
  input logic [N_SRC-1:0]  mask_w,
  input logic [N_SRC-1:0]  asg_w,
  input logic [N_SRC-1:0]  wake_w,
  input logic [N_SRC-1:0]  rise
);
  assert_mask_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(OFF_MASK))
      |=> ((mask_w & $past(bus_wdata_i)) == $past(bus_wdata_i)));

  assert_capture_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == ADDR_W'(OFF_RISE))
      |=> ((rise & $past(rise)) == $past(rise)));

  assert_mask_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_w == '0) |=> (!req0_o && !req1_o));

  assert_req0_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(active & mask_w & asg_w)) |=> req0_o);

  assert_req1_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(active & mask_w & ~asg_w)) |=> !req1_o);

  assert_wake_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_w == '0) |=> !wake_o);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_wr_i   (bus_wr_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .req0_o     (req0_o),
  .req1_o     (req1_o),
  .wake_o     (wake_o),
  .active     (active),
  .mask_w     (mask_w),
  .asg_w      (asg_w),
  .wake_w     (wake_w),
  .rise       (rise)
);

// File: tb/sim_irq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] periph = '0;
  logic        req0, req1, wake;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_ctrl u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .bus_wr_i    (wr),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .periph_irq_i(periph),
    .req0_o      (req0),
    .req1_o      (req1),
    .wake_o      (wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle();
    repeat (6) @(posedge clk);
  endtask

  task automatic scrub();
    logic [7:0] clr_offs [7] = '{8'h44, 8'h4C, 8'h54, 8'h5C, 8'h64, 8'h6C, 8'h74};
    for (int k = 0; k < 7; k++) bus_wr(clr_offs[k], 32'hFFFF_FFFF);
    bus_wr(8'h80, 32'h0);
    periph = '0;
    settle();
    bus_wr(8'h78, 32'hFFFF_FFFF);
    bus_wr(8'h7C, 32'hFFFF_FFFF);
    settle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    logic [7:0] offs [10] = '{8'h40, 8'h48, 8'h50, 8'h58, 8'h60, 8'h68, 8'h70, 8'h78, 8'h7C, 8'h80};
    for (int k = 0; k < 10; k++) begin
      bus_rd(offs[k], v);
      check("R1 word after reset", v, 32'h0);
    end
    check("R1 outputs after reset", {29'h0, req0, req1, wake}, 32'h0);
  endtask

  task automatic t_setclr();
    logic [31:0] v;
    bus_wr(8'h70, 32'h0000_00F0);
    bus_wr(8'h70, 32'h0F00_0000);
    bus_rd(8'h70, v); check("R2 mask set accumulates", v, 32'h0F00_00F0);
    bus_wr(8'h74, 32'h0000_0030);
    bus_rd(8'h70, v); check("R2 mask clear selective", v, 32'h0F00_00C0);
    bus_wr(8'h48, 32'hA5A5_0000);
    bus_wr(8'h4C, 32'h8000_0000);
    bus_rd(8'h48, v); check("R2 mode bit1 set/clear", v, 32'h25A5_0000);
    bus_wr(8'h60, 32'h0000_0003);
    bus_rd(8'h60, v); check("R2 route word", v, 32'h0000_0003);
    scrub();
  endtask

  task automatic t_shared_clear();
    logic [31:0] v;
    bus_wr(8'h50, 32'h0000_00FF);
    bus_wr(8'h54, 32'h0000_000F);
    bus_rd(8'h50, v); check("R11 write 0x54 clears mode bit2", v, 32'h0000_00F0);
    bus_wr(8'h58, 32'h0000_0003);
    bus_wr(8'h5C, 32'h0000_0001);
    bus_rd(8'h58, v); check("R11 write 0x5C clears select", v, 32'h0000_0002);
    scrub();
  endtask

  task automatic t_edges();
    logic [31:0] v;
    // src0 rising only, src1 falling only, src2 both
    bus_wr(8'h40, 32'h0000_0005);
    bus_wr(8'h48, 32'h0000_0006);
    bus_wr(8'h80, 32'h0000_0007);
    settle();
    bus_rd(8'h78, v); check("R4 rising captured on rise/both", v, 32'h0000_0005);
    bus_rd(8'h7C, v); check("R4 no fall yet", v, 32'h0);
    bus_wr(8'h80, 32'h0000_0000);
    settle();
    bus_rd(8'h7C, v); check("R4 falling captured on fall/both", v, 32'h0000_0006);
    bus_rd(8'h78, v); check("R7 capture holds without clear", v, 32'h0000_0005);
    // route src0 to line 0, src1 to line 1
    bus_wr(8'h70, 32'h0000_0003);
    bus_wr(8'h60, 32'h0000_0001);
    settle();
    bus_rd(8'h54, v); check("R9 line0 status", v, 32'h0000_0001);
    bus_rd(8'h5C, v); check("R9 line1 status", v, 32'h0000_0002);
    check("R9 both lines raised", {30'h0, req0, req1}, 32'h3);
    bus_wr(8'h78, 32'h0000_0001);
    settle();
    check("R9 line0 drops after clear", {31'h0, req0}, 32'h0);
    bus_rd(8'h78, v); check("R7 clear one bit only", v, 32'h0000_0004);
    scrub();
  endtask

  task automatic t_levels();
    logic [31:0] v;
    // src3 high (101), src4 low (110), src5 off (000), src6 off (100)
    bus_wr(8'h40, 32'h0000_0008);
    bus_wr(8'h48, 32'h0000_0010);
    bus_wr(8'h50, 32'h0000_0058);
    bus_wr(8'h70, 32'h0000_0078);
    bus_wr(8'h60, 32'h0000_0078);
    settle();
    bus_rd(8'h54, v); check("R5 inputs low: low-level only", v, 32'h0000_0010);
    bus_wr(8'h80, 32'h0000_0078);
    settle();
    bus_rd(8'h54, v); check("R5 inputs high: high-level only", v, 32'h0000_0008);
    bus_rd(8'h78, v); check("R5 no capture in level/off modes", v, 32'h0);
    bus_wr(8'h80, 32'h0);
    settle();
    bus_rd(8'h7C, v); check("R5 no falling capture in level/off modes", v, 32'h0);
    scrub();
  endtask

  task automatic t_all();
    logic [31:0] v;
    bus_wr(8'h40, 32'h0000_0080);
    bus_wr(8'h48, 32'h0000_0080);
    bus_wr(8'h50, 32'h0000_0080);
    bus_wr(8'h70, 32'h0000_0080);
    settle();
    bus_rd(8'h5C, v); check("R6 active while low", v, 32'h0000_0080);
    check("R6 line1 raised", {31'h0, req1}, 32'h1);
    bus_wr(8'h80, 32'h0000_0080);
    settle();
    bus_rd(8'h5C, v); check("R6 active while high", v, 32'h0000_0080);
    bus_rd(8'h78, v); check("R6 rising captured", v, 32'h0000_0080);
    scrub();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    bus_wr(8'h40, 32'h0000_0100);
    settle();
    bus_wr(8'h80, 32'h0000_0100);
    bus_wr(8'h78, 32'h0000_0100);  // lands with the new edge
    bus_rd(8'h78, v); check("R7 new edge beats clear", v, 32'h0000_0100);
    bus_wr(8'h78, 32'h0000_0100);
    bus_rd(8'h78, v); check("R7 clear without edge", v, 32'h0);
    scrub();
  endtask

  task automatic t_mask();
    logic [31:0] v;
    bus_wr(8'h40, 32'h0000_0200);
    bus_wr(8'h50, 32'h0000_0200);
    bus_wr(8'h60, 32'h0000_0200);
    bus_wr(8'h80, 32'h0000_0200);
    settle();
    bus_rd(8'h54, v); check("R8 masked status hidden", v, 32'h0);
    check("R8 masked lines low", {30'h0, req0, req1}, 32'h0);
    bus_wr(8'h70, 32'h0000_0200);
    settle();
    check("R8 unmasked raises line0", {30'h0, req0, req1}, 32'h2);
    scrub();
  endtask

  task automatic t_periph();
    logic [31:0] v;
    bus_wr(8'h40, 32'h0000_0010);
    bus_wr(8'h50, 32'h0000_0010);
    bus_wr(8'h60, 32'h0000_0010);
    bus_wr(8'h70, 32'h0000_0010);
    bus_wr(8'h58, 32'h0000_0010);
    settle();
    @(negedge clk);
    periph = 32'h0000_0010;
    @(posedge clk);
    bus_rd(8'h54, v); check("R3 one edge: not yet seen", v, 32'h0);
    @(posedge clk);
    bus_rd(8'h54, v); check("R3 two edges: peripheral seen", v, 32'h0000_0010);
    bus_wr(8'h80, 32'h0);
    settle();
    bus_rd(8'h54, v); check("R3 test bit ignored when selecting wire", v, 32'h0000_0010);
    bus_wr(8'h5C, 32'h0000_0010);
    settle();
    bus_rd(8'h54, v); check("R3 test bit selected, wire ignored", v, 32'h0);
    scrub();
  endtask

  task automatic t_wake();
    bus_wr(8'h40, 32'h0000_0400);
    bus_wr(8'h50, 32'h0000_0400);
    bus_wr(8'h80, 32'h0000_0400);
    settle();
    check("R10 no wake without enable", {31'h0, wake}, 32'h0);
    bus_wr(8'h68, 32'h0000_0400);
    settle();
    check("R10 wake with mask clear", {31'h0, wake}, 32'h1);
    check("R10 requests stay low", {30'h0, req0, req1}, 32'h0);
    scrub();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk);
    t_reset();
    t_setclr();
    t_shared_clear();
    t_edges();
    t_levels();
    t_all();
    t_collide();
    t_mask();
    t_periph();
    t_wake();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule